// File: doc/BRIEF.md
# NaN Classifier and Quieting Unit

This block inspects one IEEE floating-point operand (half, single or double width, fixed at build time by a parameter) and tells the surrounding datapath whether that operand is a quiet NaN, a signaling NaN, or neither. In the same cycle it forms two values. The first is the operand made safe to propagate: a signaling NaN is silenced and any other value passes through unchanged. The second is the format's default NaN for the current mode.

Three mode inputs are sampled together with the operand. `snan_one` inverts the meaning of the fraction's leading bit, so that a set leading bit marks a signaling NaN. `no_snan` treats every NaN as quiet. `dflt_neg` picks the sign of the default NaN in the normal polarity. A result is captured on every cycle where `in_valid` is high and appears on the outputs one clock later. Between captures the outputs keep their last value.

Top module: `nanq_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high; reset drives `out_valid`, both flags and both data outputs to zero.
- R2: With `snan_one` = 0 and `no_snan` = 0, `out_qnan` is set when the exponent field is all ones and the fraction's leading bit (bit FW-1; bit 22 for single) is one.
- R3: With `snan_one` = 0 and `no_snan` = 0, `out_snan` is set when the exponent field is all ones, the fraction's leading bit is zero and the remaining fraction bits are not all zero. An infinity sets neither flag, and the two flags are never both set.
- R4: With `snan_one` = 1 and `no_snan` = 0, the quiet and signaling tests of R2 and R3 swap: a set leading bit marks a signaling NaN, and a clear leading bit with a nonzero remaining fraction marks a quiet NaN.
- R5: With `no_snan` = 1, every NaN (exponent all ones, fraction nonzero) is reported as quiet and nothing is reported as signaling, whatever the value of `snan_one`.
- R6: In the normal polarity, the silenced output of a signaling NaN is the operand with the fraction's leading bit set (bit 9 for half, 22 for single, 51 for double).
- R7: In the inverted polarity, the silenced output of a signaling NaN is the default NaN of R9.
- R8: An operand that is not reported as a signaling NaN appears unchanged on `out_silenced`.
- R9: With `snan_one` = 1, the default NaN has sign 0, an all-ones exponent, a zero leading fraction bit and all other fraction bits one (0x7FBFFFFF for single, 0x7DFF for half).
- R10: With `snan_one` = 0, the default NaN has its sign equal to `dflt_neg`, an all-ones exponent, leading fraction bit one and all other fraction bits zero (0x7FC00000 or 0xFFC00000 for single, 0x7E00 or 0xFE00 for half).
- R11: In a cycle after one where `in_valid` was low, the flags and data outputs keep the values they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and modes are captured when high |
| in_operand | input | W (16/32/64) | Floating-point operand |
| snan_one | input | 1 | Inverted polarity: leading fraction bit set means signaling |
| no_snan | input | 1 | Treat every NaN as quiet |
| dflt_neg | input | 1 | Sign of the default NaN in normal polarity |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_qnan | output | 1 | Operand was a quiet NaN |
| out_snan | output | 1 | Operand was a signaling NaN |
| out_silenced | output | W | Operand with any signaling NaN silenced |
| out_dflt | output | W | Default NaN for the captured modes |

## Verification
The assertions assume that `in_valid`, the operand and the mode inputs are driven to known values whenever reset is released. They also assume that the mode inputs are meaningful only in cycles where `in_valid` is high. The stimulus changes all inputs only on the falling clock edge and holds them known throughout. It mixes valid and idle cycles, so the hold behaviour can be observed. It uses each mode combination, including `no_snan` together with inverted polarity. The operands are infinities, NaNs with only the leading bit set, NaNs with only low fraction bits set, ordinary numbers and random words.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    // Format selector values for the FMT parameter
    localparam int FMT_HALF   = 0;
    localparam int FMT_SINGLE = 1;
    localparam int FMT_DOUBLE = 2;

    function automatic int exp_width(input int fmt);
        case (fmt)
            FMT_HALF:   return 5;
            FMT_DOUBLE: return 11;
            default:    return 8;
        endcase
    endfunction

    function automatic int frac_width(input int fmt);
        case (fmt)
            FMT_HALF:   return 10;
            FMT_DOUBLE: return 52;
            default:    return 23;
        endcase
    endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] operand,
    input  logic         snan_one,
    input  logic         no_snan,
    output logic         is_q,
    output logic         is_s
);
    logic exp_ones;
    logic lead_bit;
    logic rest_nz;
    logic any_nan;
    logic lead_nan;   // NaN with leading fraction bit set
    logic tail_nan;   // NaN with leading bit clear, tail nonzero

    assign exp_ones = &operand[FW+EW-1:FW];
    assign lead_bit = operand[FW-1];

    generate
        if (FW > 1) begin : g_tail
            assign rest_nz = |operand[FW-2:0];
        end else begin : g_no_tail
            assign rest_nz = 1'b0;
        end
    endgenerate

    assign any_nan  = exp_ones & (lead_bit | rest_nz);
    assign lead_nan = exp_ones & lead_bit;
    assign tail_nan = exp_ones & ~lead_bit & rest_nz;

    always_comb begin
        if (no_snan) begin
            is_q = any_nan;
            is_s = 1'b0;
        end else if (snan_one) begin
            is_q = tail_nan;
            is_s = lead_nan;
        end else begin
            is_q = lead_nan;
            is_s = tail_nan;
        end
    end
endmodule

// File: rtl/nanq_default.sv
module nanq_default #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = 1 + EW + FW
) (
    input  logic         snan_one,
    input  logic         neg,
    output logic [W-1:0] dflt
);
    localparam logic [FW-1:0] FRAC_INV = {1'b0, {(FW-1){1'b1}}};
    localparam logic [FW-1:0] FRAC_NRM = {1'b1, {(FW-1){1'b0}}};

    always_comb begin
        dflt[W-1]       = snan_one ? 1'b0 : neg;
        dflt[W-2:FW]    = '1;
        dflt[FW-1:0]    = snan_one ? FRAC_INV : FRAC_NRM;
    end
endmodule

// File: rtl/nanq_silence.sv
module nanq_silence #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] operand,
    input  logic         is_s,
    input  logic         snan_one,
    input  logic [W-1:0] dflt,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] LEAD_MASK = W'(1) << (FW - 1);

    always_comb begin
        if (!is_s)         result = operand;
        else if (snan_one) result = dflt;
        else               result = operand | LEAD_MASK;
    end
endmodule

// File: rtl/nanq_top.sv
module nanq_top #(
    parameter int FMT = nanq_pkg::FMT_SINGLE,
    localparam int EW = nanq_pkg::exp_width(FMT),
    localparam int FW = nanq_pkg::frac_width(FMT),
    localparam int W  = 1 + EW + FW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_operand,
    input  logic         snan_one,
    input  logic         no_snan,
    input  logic         dflt_neg,
    output logic         out_valid,
    output logic         out_qnan,
    output logic         out_snan,
    output logic [W-1:0] out_silenced,
    output logic [W-1:0] out_dflt
);
    typedef struct packed {
        logic         vld;
        logic         qnan;
        logic         snan;
        logic [W-1:0] sil;
        logic [W-1:0] dflt;
    } res_t;

    res_t state_d, state_q;

    logic         cls_q, cls_s;
    logic [W-1:0] dflt_w, sil_w;

    nanq_classify #(.EW(EW), .FW(FW)) u_classify (
        .operand  (in_operand),
        .snan_one (snan_one),
        .no_snan  (no_snan),
        .is_q     (cls_q),
        .is_s     (cls_s)
    );

    nanq_default #(.EW(EW), .FW(FW)) u_default (
        .snan_one (snan_one),
        .neg      (dflt_neg),
        .dflt     (dflt_w)
    );

    nanq_silence #(.EW(EW), .FW(FW)) u_silence (
        .operand  (in_operand),
        .is_s     (cls_s),
        .snan_one (snan_one),
        .dflt     (dflt_w),
        .result   (sil_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.qnan = cls_q;
            state_d.snan = cls_s;
            state_d.sil  = sil_w;
            state_d.dflt = dflt_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid    = state_q.vld;
    assign out_qnan     = state_q.qnan;
    assign out_snan     = state_q.snan;
    assign out_silenced = state_q.sil;
    assign out_dflt     = state_q.dflt;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_qnan && out_snan));

    // R5
    nosig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid) && $past(no_snan) |-> !out_snan);

    // R8
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid) && !out_snan |-> out_silenced == $past(in_operand));

    // R6
    lead_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid) && !$past(snan_one) && out_snan |-> out_silenced[FW-1]);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid) |-> $stable(out_silenced) && $stable(out_dflt));
endmodule

// File: tb/nanq_top_bench.sv
module nanq_top_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_operand = '0;
    logic         snan_one = 1'b0;
    logic         no_snan = 1'b0;
    logic         dflt_neg = 1'b0;
    logic         out_valid, out_qnan, out_snan;
    logic [W-1:0] out_silenced, out_dflt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    nanq_top u_nanq_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .snan_one(snan_one), .no_snan(no_snan), .dflt_neg(dflt_neg),
        .out_valid(out_valid), .out_qnan(out_qnan), .out_snan(out_snan),
        .out_silenced(out_silenced), .out_dflt(out_dflt)
    );

    always #5 clk = ~clk;

    // Reference model state (what the outputs should show)
    logic         e_vld = 0, e_q = 0, e_s = 0;
    logic [W-1:0] e_sil = '0, e_dflt = '0;

    function automatic logic [31:0] ref_dflt(input logic one, input logic neg);
        if (one) return 32'h7FBF_FFFF;          // R9
        return neg ? 32'hFFC0_0000 : 32'h7FC0_0000; // R10
    endfunction

    always @(posedge clk) begin
        logic [31:0] mag;
        logic nan_any, hi, lo, q, s;
        logic [31:0] d;
        if (!rst_n) begin
            e_vld = 0; e_q = 0; e_s = 0; e_sil = '0; e_dflt = '0;
        end else begin
            e_vld = in_valid;
            if (in_valid) begin
                mag = in_operand << 1;
                nan_any = mag > 32'hFF00_0000;
                hi = mag >= 32'hFF80_0000;
                lo = nan_any && !hi;
                if (no_snan)       begin q = nan_any; s = 0;  end
                else if (snan_one) begin q = lo;      s = hi; end
                else               begin q = hi;      s = lo; end
                d = ref_dflt(snan_one, dflt_neg);
                e_q = q; e_s = s; e_dflt = d;
                if (!s)            e_sil = in_operand;
                else if (snan_one) e_sil = d;
                else               e_sil = in_operand + ((in_operand & 32'h0040_0000) == 0 ? 32'h0040_0000 : 0);
            end
        end
    end

    task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            cmp("R1 valid", W'(out_valid), W'(e_vld));
            cmp("R2 R4 R5 quiet flag", W'(out_qnan), W'(e_q));
            cmp("R3 R4 R5 signaling flag", W'(out_snan), W'(e_s));
            cmp("R6 R7 R8 R11 silenced", out_silenced, e_sil);
            cmp("R9 R10 R11 default", out_dflt, e_dflt);
        end
    end

    task automatic apply(input logic [31:0] op, input logic one, input logic nos,
                         input logic neg, input logic v);
        @(negedge clk);
        in_operand = op; snan_one = one; no_snan = nos; dflt_neg = neg; in_valid = v;
    endtask

    task automatic sweep(input logic one, input logic nos, input logic neg);
        apply(32'h7FC0_0001, one, nos, neg, 1); // lead set + tail
        apply(32'h7FC0_0000, one, nos, neg, 1); // lead only
        apply(32'h7F80_0001, one, nos, neg, 1); // tail only
        apply(32'hFFA0_0000, one, nos, neg, 1); // negative tail NaN
        apply(32'h7F80_0000, one, nos, neg, 1); // +inf (R3: neither)
        apply(32'hFF80_0000, one, nos, neg, 1); // -inf
        apply(32'h3F80_0000, one, nos, neg, 1); // ordinary value (R8)
        apply(32'h7FFF_FFFF, one, nos, neg, 1);
        apply(32'h1234_5678, one, nos, neg, 0); // idle: hold (R11)
        apply(32'h7F80_0001, one, nos, neg, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 R3 R6 R10: normal polarity, both sign choices
        sweep(0, 0, 0);
        sweep(0, 0, 1);
        // R4 R7 R9: inverted polarity
        sweep(1, 0, 0);
        sweep(1, 0, 1);
        // R5: no-signaling mode in both polarities
        sweep(0, 1, 0);
        sweep(1, 1, 1);
        // Mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 3 == 0) r[30:23] = 8'hFF;
            if (i % 7 == 0) r[21:0] = '0;
            apply(r, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0);
        end
        // R1: reset in the middle clears everything
        apply(32'h7F80_0001, 0, 0, 1, 1);
        @(negedge clk); rst_n = 0; in_valid = 1;
        @(negedge clk); @(negedge clk); rst_n = 1; in_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule